// File: doc/BRIEF.md
# IQ Receive Decimator and Sample Formatter

This block sits between a receive ADC and a host capture port. The ADC delivers one byte per clock, and I and Q bytes alternate. A phase input marks whether the current byte is an I or a Q sample. The block keeps one complete I/Q pair out of every N pairs, where N is between 1 and 8 and is chosen by a 3-bit select input. It converts each kept byte from offset binary to two's complement and presents it on a registered host byte with a one-clock valid strobe.

The Q channel has an extra control. By default a Q byte is both sign-converted and negated, which undoes a polarity flip in the analog front end. When the Q-invert control is raised, Q is converted in the same way as I. An enable input gates the whole path. The package also provides a helper for control software: it turns a decimation factor into a select code and reports whether the factor is valid.

Top module: `iq_decim_fmt`

## Requirements
- R1: With select value s, held steady since the previous I sample, the block keeps one pair and then drops the next (7 - s) pairs, and this pattern repeats. 3'b111 keeps every pair and 3'b000 keeps one pair in eight. The first pair after reset or after enable rises is always kept.
- R2: A kept I byte (phase input 0) appears on the host byte one clock later, XORed with 8'h80.
- R3: A kept Q byte (phase input 1) with Q-invert low appears one clock later, XORed with 8'h7F.
- R4: A kept Q byte with Q-invert high appears one clock later, XORed with 8'h80.
- R5: The block decides whether to keep a pair only on the I sample. A Q sample is kept exactly when the I sample just before it was kept.
- R6: When the select value on an I sample differs from its value on the previous I sample, that pair is kept and the skip count restarts from the new value. A change made on a Q sample takes effect at the next I sample.
- R7: The valid output is high for exactly one clock per kept byte. While valid is low, the host byte keeps its last value.
- R8: While enable is low, valid stays low and the skip counter is held at its reset state, so the first pair after enable returns is kept.
- R9: During reset, valid is 0, the host byte is 8'h00 and the skip counter is set to all ones.
- R10: The package helper maps a factor f in the range 1 to 8 to the select code ~(f-1) and marks it valid. It marks f = 0 and f > 8 invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Stream enable |
| adc_byte | input | DATA_W | Offset-binary ADC sample |
| q_phase | input | 1 | 0 = I sample, 1 = Q sample |
| decim_sel | input | SEL_W | Inverted decimation select |
| q_flip | input | 1 | 1 = Q uses the I conversion; 0 = Q is also negated |
| host_byte | output | DATA_W | Registered two's-complement sample |
| host_vld | output | 1 | One-clock strobe for each kept byte |

## Verification
A corrupted skip counter, or a wrongly latched select copy, changes which I sample raises valid. The error therefore shows up at the next pair boundary, at most eight pairs later. A lost pair flag shows up one clock after the I sample, as a Q byte that is missing or extra. A wrong conversion mask shows up in the very next valid byte. The bench model predicts valid and the byte on every clock, so any such deviation is reported in the cycle where it first reaches the ports.

// File: rtl/iq_decim_pkg.sv
package iq_decim_pkg;

   typedef enum logic {PH_I = 1'b0, PH_Q = 1'b1} iq_phase_e;

   // Software-side helper: is a decimation factor representable with sel_w bits?
   function automatic bit factor_ok(input int unsigned f, input int unsigned sel_w);
      return (f >= 1) && ((f - 1) < (32'd1 << sel_w));
   endfunction

   // Select code for a factor: the complement of the skip count.
   function automatic int unsigned factor_sel(input int unsigned f, input int unsigned sel_w);
      int unsigned all_ones;
      all_ones = (32'd1 << sel_w) - 1;
      return all_ones ^ ((f - 1) & all_ones);
   endfunction

endpackage

// File: rtl/iq_decim_ctl.sv
module iq_decim_ctl #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             is_q,
   input  logic [SEL_W-1:0] sel,
   output logic             keep
);
   localparam logic [SEL_W-1:0] TOP = '1;

   logic [SEL_W-1:0] cnt;
   logic [SEL_W-1:0] sel_q;
   logic             pair_kept;
   logic             take_i;

   // A pair is taken when the count has wrapped or the select has just changed.
   assign take_i = (sel != sel_q) || (cnt == TOP);
   assign keep   = en && (is_q ? pair_kept : take_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= TOP;
         sel_q     <= TOP;
         pair_kept <= 1'b0;
      end else if (!en) begin
         cnt       <= TOP;
         sel_q     <= sel;
         pair_kept <= 1'b0;
      end else if (!is_q) begin
         sel_q     <= sel;
         pair_kept <= take_i;
         cnt       <= take_i ? sel : cnt + SEL_W'(1);
      end else begin
         pair_kept <= 1'b0;
      end
   end
endmodule

// File: rtl/iq_fmt_lane.sv
module iq_fmt_lane #(
   parameter int DATA_W    = 8,
   parameter bit Q_FLIP_EN = 1'b1
) (
   input  logic [DATA_W-1:0] din,
   input  logic              is_q,
   input  logic              q_flip,
   output logic [DATA_W-1:0] dout
);
   localparam logic [DATA_W-1:0] SIGN_MASK = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] NEG_MASK  = ~SIGN_MASK;

   logic use_sign;

   generate
      if (Q_FLIP_EN) begin : g_flip
         assign use_sign = !is_q || q_flip;
      end else begin : g_fixed
         logic unused_flip;
         assign unused_flip = q_flip;
         assign use_sign    = !is_q;
      end
   endgenerate

   assign dout = din ^ (use_sign ? SIGN_MASK : NEG_MASK);
endmodule

// File: rtl/iq_decim_fmt.sv
module iq_decim_fmt #(
   parameter int DATA_W    = 8,
   parameter int SEL_W     = 3,
   parameter bit Q_FLIP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [DATA_W-1:0] adc_byte,
   input  logic              q_phase,
   input  logic [SEL_W-1:0]  decim_sel,
   input  logic              q_flip,
   output logic [DATA_W-1:0] host_byte,
   output logic              host_vld
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("iq_decim_fmt: DATA_W must be at least 2");
      end
      if (SEL_W < 1 || SEL_W > 16) begin : g_bad_sel
         $error("iq_decim_fmt: SEL_W out of range");
      end
   endgenerate

   logic              keep;
   logic [DATA_W-1:0] conv;

   iq_decim_ctl #(.SEL_W(SEL_W)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .is_q  (q_phase),
      .sel   (decim_sel),
      .keep  (keep)
   );

   iq_fmt_lane #(.DATA_W(DATA_W), .Q_FLIP_EN(Q_FLIP_EN)) u_lane (
      .din    (adc_byte),
      .is_q   (q_phase),
      .q_flip (q_flip),
      .dout   (conv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_byte <= '0;
         host_vld  <= 1'b0;
      end else begin
         host_vld <= keep;
         if (keep) host_byte <= conv;
      end
   end
endmodule

// File: rtl/iq_decim_fmt_chk.sv
module iq_decim_fmt_chk #(
   parameter int DATA_W    = 8,
   parameter int SEL_W     = 3,
   parameter bit Q_FLIP_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [DATA_W-1:0] adc_byte,
   input logic              q_phase,
   input logic [SEL_W-1:0]  decim_sel,
   input logic              q_flip,
   input logic [DATA_W-1:0] host_byte,
   input logic              host_vld
);
   localparam logic [DATA_W-1:0] SIGN_MASK = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] NEG_MASK  = ~SIGN_MASK;

   assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !host_vld);

   assert_i_convert_R2: assert property (@(posedge clk) disable iff (!rst_n)
      host_vld && !$past(q_phase) |-> host_byte == ($past(adc_byte) ^ SIGN_MASK));

   assert_q_convert_R3: assert property (@(posedge clk) disable iff (!rst_n)
      host_vld && $past(q_phase) && !(Q_FLIP_EN && $past(q_flip))
      |-> host_byte == ($past(adc_byte) ^ NEG_MASK));

   assert_q_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
      host_vld && $past(q_phase) && Q_FLIP_EN && $past(q_flip)
      |-> host_byte == ($past(adc_byte) ^ SIGN_MASK));

   assert_q_follows_i_R5: assert property (@(posedge clk) disable iff (!rst_n)
      host_vld && $past(q_phase) |-> $past(host_vld));

   assert_hold_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !host_vld |-> host_byte == $past(host_byte));

   assert_keep_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en) && !$past(q_phase) && ($past(decim_sel) == '1) |-> host_vld);
endmodule

bind iq_decim_fmt iq_decim_fmt_chk #(
   .DATA_W(DATA_W), .SEL_W(SEL_W), .Q_FLIP_EN(Q_FLIP_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .adc_byte(adc_byte), .q_phase(q_phase),
   .decim_sel(decim_sel), .q_flip(q_flip), .host_byte(host_byte), .host_vld(host_vld)
);

// File: tb/sim_iq_decim_fmt.sv
module sim_iq_decim_fmt;
   import iq_decim_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] adc = 8'h00;
   logic       q_phase = 1'b0;
   logic [2:0] sel = 3'b111;
   logic       q_flip = 1'b0;
   logic [7:0] hb;
   logic       hv;

   int total = 0;
   int bad = 0;

   // reference model state
   int         skip_left = 0;
   int         prev_sel = 7;
   bit         kept = 0;
   logic [7:0] exp_byte = 8'h00;
   bit         exp_vld = 0;
   string      vtag = "R9";
   string      btag = "R9";

   always #4 clk = ~clk;

   iq_decim_fmt u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .adc_byte(adc), .q_phase(q_phase),
      .decim_sel(sel), .q_flip(q_flip), .host_byte(hb), .host_vld(hv)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Evaluate the model for the inputs now applied, clock once, compare.
   task automatic cyc();
      if (!en) begin
         exp_vld = 0; skip_left = 0; kept = 0; prev_sel = int'(sel); vtag = "R8";
      end else if (!q_phase) begin
         bit chg;
         bit take;
         chg  = (int'(sel) != prev_sel);
         take = chg || (skip_left == 0);
         prev_sel = int'(sel);
         if (take) skip_left = 7 - int'(sel);
         else skip_left = skip_left - 1;
         kept = take; exp_vld = take;
         vtag = chg ? "R6" : "R1";
         if (take) begin exp_byte = adc ^ 8'h80; btag = "R2"; end
      end else begin
         exp_vld = kept; vtag = "R5";
         if (kept) begin
            exp_byte = adc ^ (q_flip ? 8'h80 : 8'h7F);
            btag = q_flip ? "R4" : "R3";
         end
         kept = 0;
      end
      if (!exp_vld) btag = "R7";
      @(posedge clk);
      @(negedge clk);
      chk(vtag, int'(hv), int'(exp_vld));
      chk(btag, int'(hb), int'(exp_byte));
   endtask

   task automatic pair(input logic [7:0] i_b, input logic [7:0] q_b);
      adc = i_b; q_phase = 1'b0; cyc();
      adc = q_b; q_phase = 1'b1; cyc();
   endtask

   task automatic run(input int n, input int seed);
      for (int k = 0; k < n; k++)
         pair(8'((seed + k * 37) & 255), 8'((seed * 3 + k * 91 + 17) & 255));
   endtask

   initial begin
      #(8 * 200000);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9", int'(hv), 0);
      chk("R9", int'(hb), 0);
      rst_n = 1'b1;
      // R10: factor helper
      for (int f = 0; f <= 9; f++) begin
         chk("R10", int'(factor_ok(f, 3)), (f >= 1 && f <= 8) ? 1 : 0);
         if (f >= 1 && f <= 8) chk("R10", int'(factor_sel(f, 3)), 7 - (f - 1));
      end
      // disabled: nothing comes out (R8)
      en = 1'b0; run(2, 5);
      en = 1'b1;
      // R1: keep every pair, boundary values, R3 default Q path
      sel = 3'b111;
      pair(8'h00, 8'h00); pair(8'h80, 8'h80); pair(8'hFF, 8'h7F); pair(8'h7F, 8'hFF);
      run(4, 11);
      // R4: flipped Q
      q_flip = 1'b1; run(4, 23); pair(8'h80, 8'h00);
      // R1: one in two, one in eight (R6 on change)
      q_flip = 1'b0; sel = 3'b110; run(7, 40);
      sel = 3'b000; run(18, 77);
      q_flip = 1'b1; sel = 3'b011; run(11, 9);
      // R6: change on a Q sample is deferred
      sel = 3'b101;
      adc = 8'h12; q_phase = 1'b0; cyc();
      sel = 3'b010; adc = 8'h34; q_phase = 1'b1; cyc();
      run(9, 60);
      // R8: disable in the middle, counter restarts
      en = 1'b0; run(3, 3);
      en = 1'b1; run(8, 101);
      // R6: rapid changes
      for (int s = 0; s < 8; s++) begin
         sel = 3'(s); run(3, s * 13);
      end
      en = 1'b0; adc = 8'h55; q_phase = 1'b0; cyc();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule